// File: doc/BRIEF.md
# Cipher DMA Channel

This block moves 32-bit words between memory and a block-cipher datapath in both directions. A one-cycle start pulse, given while the channel is idle, captures a source base address, a destination base address and a length counted in words. The channel reads words through a request/grant read port and buffers them in a small input FIFO that feeds the cipher. It then takes the cipher's results one at a time and writes them through a request/grant write port to the destination. It signals `done` only after the last result word has been written, and it signals `error` when either port returns a bus fault.

Each direction has its own address mode and its own byte-order option. In fixed mode every beat uses the same address. In incrementing mode the address steps by 4 after each beat. After a `done`, software may start the channel again with new addresses and a new length to process the next chunk.

The control state machine has four states:
- `ST_IDLE`: accepts a start. It goes to `ST_RUN`, or to `ST_FINISH` when the length is zero.
- `ST_RUN`: moves data. It goes to `ST_FINISH` on the last good write and to `ST_ABORT` on a bus fault.
- `ST_FINISH`: raises `done` for one cycle, then returns to `ST_IDLE`.
- `ST_ABORT`: raises `error` for one cycle, flushes both directions, then returns to `ST_IDLE`.

Top module: `cipher_dma_chan`

## Requirements
- R1: A transfer started with length N issues exactly N granted reads and exactly N granted writes.
- R2: A direction whose incrementing bit is 1 uses address base+4·i for beat i. With the bit at 0 it uses the base for every beat. The two low address bits are always driven as zero. A request, and its address, is held until it is granted.
- R3: When a direction's swap bit is 1, the four bytes of every word are reversed as the word passes that direction: byte 0 is exchanged with byte 3, and byte 1 with byte 2. Write data stays stable while a write waits for its grant.
- R4: `done` is a single-cycle pulse in the cycle right after the grant of the N-th write. It never appears before that write.
- R5: A start with length 0 raises `done` one cycle later and issues no read or write request. No request is ever driven while `busy` is low.
- R6: A granted read or write that returns an error raises `error` for one cycle in the next cycle. It aborts both directions and returns the channel to idle with `busy` low. It never raises `done`, and it issues no further requests.
- R7: A start pulse that arrives while `busy` is high is ignored. The running transfer keeps its addresses, length and options.
- R8: The input FIFO holds 4 words. With the cipher refusing input, the channel completes exactly 4 reads and then stalls until space frees. Offered cipher input stays stable until it is accepted.
- R9: After a `done`, a new start with new addresses and options runs a fresh, correct transfer.
- R10: After reset, `busy`, `done`, `error`, `rd_req` and `wr_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, honoured only when idle |
| len_words | input | LW | Transfer length in 32-bit words |
| rx_base | input | AW | Source start address for memory reads |
| tx_base | input | AW | Destination start address for memory writes |
| rx_incr | input | 1 | Read address mode: 1 = increment by 4, 0 = fixed |
| tx_incr | input | 1 | Write address mode: 1 = increment by 4, 0 = fixed |
| rx_swap | input | 1 | Reverse byte order of words read |
| tx_swap | input | 1 | Reverse byte order of words written |
| busy | output | 1 | Channel is not idle |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle bus-fault pulse |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_gnt | input | 1 | Read grant; data and fault are valid with it |
| rd_rdata | input | 32 | Read data |
| rd_err | input | 1 | Read bus fault, valid with grant |
| ci_valid | output | 1 | Word offered to the cipher |
| ci_data | output | 32 | Word to the cipher |
| ci_ready | input | 1 | Cipher accepts the word |
| co_valid | input | 1 | Cipher result available |
| co_data | input | 32 | Cipher result word |
| co_ready | output | 1 | Channel accepts the result |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address |
| wr_data | output | 32 | Write data |
| wr_gnt | input | 1 | Write grant; fault is valid with it |
| wr_err | input | 1 | Write bus fault, valid with grant |

## Verification
The assertions assume that the memory ports signal a fault only together with a grant, and that `rd_rdata` is meaningful only in a granted cycle. They also assume the cipher side follows a valid/ready handshake in which a result is never withdrawn before it is accepted. The bench meets these assumptions in three ways:
- Its memory model derives grant, data and fault at the falling edge from the request that is already present.
- Its cipher stand-in is a one-word register that holds its output until accepted and is cleared on an abort.
- It programs fault injection by beat index, so a fault always coincides with a grant.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_N  = WORD_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FINISH,
        ST_ABORT
    } cdma_state_e;

    // Reverse the byte order of one word.
    function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < BYTE_N; b++) begin
            r[b*8 +: 8] = w[(BYTE_N-1-b)*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/cdma_fifo.sv
module cdma_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[rp_q];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= step(wp_q);
            if (do_pop)  rp_q <= step(rp_q);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wp_q] <= din;
    end

endmodule

// File: rtl/cdma_rd_path.sv
module cdma_rd_path
    import cdma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LW    = 16,
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              flush,
    input  logic              run,
    input  logic [AW-1:0]     base,
    input  logic [LW-1:0]     len,
    input  logic              incr_in,
    input  logic              swap_in,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_gnt,
    input  logic [WORD_W-1:0] rd_rdata,
    input  logic              rd_err,
    output logic              ci_valid,
    output logic [WORD_W-1:0] ci_data,
    input  logic              ci_ready,
    output logic              fault
);
    logic [AW-1:0]     addr_q;
    logic [LW-1:0]     issued_q;
    logic              incr_q, swap_q;
    logic              fire, push, full, empty;
    logic [WORD_W-1:0] wdata;

    assign rd_req  = run && (issued_q != len) && !full;
    assign rd_addr = addr_q;
    assign fire    = rd_req && rd_gnt;
    assign push    = fire && !rd_err;
    assign fault   = fire && rd_err;
    assign wdata   = swap_q ? byte_rev(rd_rdata) : rd_rdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            issued_q <= '0;
            incr_q   <= 1'b0;
            swap_q   <= 1'b0;
        end else if (load) begin
            addr_q   <= {base[AW-1:2], 2'b00};
            issued_q <= '0;
            incr_q   <= incr_in;
            swap_q   <= swap_in;
        end else if (push) begin
            issued_q <= issued_q + 1'b1;
            if (incr_q) addr_q <= addr_q + AW'(4);
        end
    end

    cdma_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push),
        .din   (wdata),
        .full  (full),
        .pop   (ci_valid && ci_ready),
        .dout  (ci_data),
        .empty (empty)
    );

    assign ci_valid = run && !empty;

endmodule

// File: rtl/cdma_wr_path.sv
module cdma_wr_path
    import cdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              flush,
    input  logic              run,
    input  logic [AW-1:0]     base,
    input  logic [LW-1:0]     len,
    input  logic              incr_in,
    input  logic              swap_in,
    input  logic              co_valid,
    input  logic [WORD_W-1:0] co_data,
    output logic              co_ready,
    output logic              wr_req,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_gnt,
    input  logic              wr_err,
    output logic              fault,
    output logic              last
);
    logic [AW-1:0]     addr_q;
    logic [LW-1:0]     cnt_q;
    logic              incr_q, swap_q;
    logic              hold_v_q;
    logic [WORD_W-1:0] hold_d_q;
    logic              fire, good;

    assign co_ready = run && !hold_v_q;
    assign wr_req   = run && hold_v_q;
    assign wr_addr  = addr_q;
    assign wr_data  = hold_d_q;
    assign fire     = wr_req && wr_gnt;
    assign good     = fire && !wr_err;
    assign fault    = fire && wr_err;
    assign last     = good && (cnt_q == len - LW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            cnt_q    <= '0;
            incr_q   <= 1'b0;
            swap_q   <= 1'b0;
            hold_v_q <= 1'b0;
            hold_d_q <= '0;
        end else if (load) begin
            addr_q   <= {base[AW-1:2], 2'b00};
            cnt_q    <= '0;
            incr_q   <= incr_in;
            swap_q   <= swap_in;
            hold_v_q <= 1'b0;
        end else if (flush) begin
            hold_v_q <= 1'b0;
        end else begin
            if (co_valid && co_ready) begin
                hold_v_q <= 1'b1;
                hold_d_q <= swap_q ? byte_rev(co_data) : co_data;
            end else if (good) begin
                hold_v_q <= 1'b0;
                cnt_q    <= cnt_q + 1'b1;
                if (incr_q) addr_q <= addr_q + AW'(4);
            end
        end
    end

endmodule

// File: rtl/cdma_ctrl.sv
module cdma_ctrl
    import cdma_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] len_in,
    input  logic          rd_fault,
    input  logic          wr_fault,
    input  logic          wr_last,
    output logic [LW-1:0] len_q,
    output logic          load,
    output logic          flush,
    output logic          run,
    output logic          busy,
    output logic          done,
    output logic          error
);
    cdma_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            len_q <= '0;
        end else begin
            st_q <= st_d;
            if (load) len_q <= len_in;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start) st_d = (len_in == '0) ? ST_FINISH : ST_RUN;
            ST_RUN: begin
                if (rd_fault || wr_fault) st_d = ST_ABORT;
                else if (wr_last)         st_d = ST_FINISH;
            end
            ST_FINISH: st_d = ST_IDLE;
            ST_ABORT:  st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load  = (st_q == ST_IDLE) && start;
        flush = load || (st_q == ST_ABORT);
        run   = (st_q == ST_RUN);
        busy  = (st_q != ST_IDLE);
        done  = (st_q == ST_FINISH);
        error = (st_q == ST_ABORT);
    end

endmodule

// File: rtl/cipher_dma_chan.sv
module cipher_dma_chan
    import cdma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LW    = 16,
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LW-1:0]     len_words,
    input  logic [AW-1:0]     rx_base,
    input  logic [AW-1:0]     tx_base,
    input  logic              rx_incr,
    input  logic              tx_incr,
    input  logic              rx_swap,
    input  logic              tx_swap,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_gnt,
    input  logic [WORD_W-1:0] rd_rdata,
    input  logic              rd_err,
    output logic              ci_valid,
    output logic [WORD_W-1:0] ci_data,
    input  logic              ci_ready,
    input  logic              co_valid,
    input  logic [WORD_W-1:0] co_data,
    output logic              co_ready,
    output logic              wr_req,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_gnt,
    input  logic              wr_err
);
    logic [LW-1:0] len_q;
    logic          load, flush, run;
    logic          rd_fault, wr_fault, wr_last;

    cdma_ctrl #(.LW(LW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .len_in   (len_words),
        .rd_fault (rd_fault),
        .wr_fault (wr_fault),
        .wr_last  (wr_last),
        .len_q    (len_q),
        .load     (load),
        .flush    (flush),
        .run      (run),
        .busy     (busy),
        .done     (done),
        .error    (error)
    );

    cdma_rd_path #(.AW(AW), .LW(LW), .DEPTH(DEPTH)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .flush    (flush),
        .run      (run),
        .base     (rx_base),
        .len      (len_q),
        .incr_in  (rx_incr),
        .swap_in  (rx_swap),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_gnt   (rd_gnt),
        .rd_rdata (rd_rdata),
        .rd_err   (rd_err),
        .ci_valid (ci_valid),
        .ci_data  (ci_data),
        .ci_ready (ci_ready),
        .fault    (rd_fault)
    );

    cdma_wr_path #(.AW(AW), .LW(LW)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .flush    (flush),
        .run      (run),
        .base     (tx_base),
        .len      (len_q),
        .incr_in  (tx_incr),
        .swap_in  (tx_swap),
        .co_valid (co_valid),
        .co_data  (co_data),
        .co_ready (co_ready),
        .wr_req   (wr_req),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_gnt   (wr_gnt),
        .wr_err   (wr_err),
        .fault    (wr_fault),
        .last     (wr_last)
    );

endmodule

// File: rtl/cdma_checker.sv
module cdma_checker #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [LW-1:0] len_words,
    input logic          busy,
    input logic          done,
    input logic          error,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_gnt,
    input logic          rd_err,
    input logic          ci_valid,
    input logic [31:0]   ci_data,
    input logic          ci_ready,
    input logic          wr_req,
    input logic [AW-1:0] wr_addr,
    input logic [31:0]   wr_data,
    input logic          wr_gnt,
    input logic          wr_err
);
    logic rd_bad, wr_bad, any_bad;
    assign rd_bad  = rd_req && rd_gnt && rd_err;
    assign wr_bad  = wr_req && wr_gnt && wr_err;
    assign any_bad = rd_bad || wr_bad;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_gnt && !wr_bad |=> rd_req && $stable(rd_addr)); // R2
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_gnt && !rd_bad |=> wr_req && $stable(wr_addr) && $stable(wr_data)); // R3
    AST_CI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ci_valid && !ci_ready && !any_bad |=> ci_valid && $stable(ci_data)); // R8
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_req && wr_gnt && !wr_err) || $past(start && !busy && len_words == '0)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req && !wr_req); // R5
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> $past(any_bad)); // R6
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && !error && start |=> busy); // R7

endmodule

bind cipher_dma_chan cdma_checker #(.AW(AW), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .len_words (len_words),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_gnt    (rd_gnt),
    .rd_err    (rd_err),
    .ci_valid  (ci_valid),
    .ci_data   (ci_data),
    .ci_ready  (ci_ready),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_gnt    (wr_gnt),
    .wr_err    (wr_err)
);

// File: tb/tb_cipher_dma_chan.sv
module tb_cipher_dma_chan;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam logic [31:0] KEY = 32'hA5C3_0F69;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] len_words = '0;
    logic [AW-1:0] rx_base = '0, tx_base = '0;
    logic          rx_incr = 1'b0, tx_incr = 1'b0, rx_swap = 1'b0, tx_swap = 1'b0;
    logic          busy, done, error;
    logic          rd_req, rd_gnt = 1'b0, rd_err = 1'b0;
    logic [AW-1:0] rd_addr;
    logic [31:0]   rd_rdata = '0;
    logic          ci_valid, ci_ready, co_valid, co_ready;
    logic [31:0]   ci_data, co_data;
    logic          wr_req, wr_gnt = 1'b0, wr_err = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;

    int checks = 0, errors = 0;
    int cyc = 0, gsel = 0;
    int rd_fires = 0, wr_n = 0, done_n = 0, err_n = 0;
    int done_cyc = 0, last_wr_cyc = 0;
    int rd_err_idx = -1, wr_err_idx = -1;
    logic [AW-1:0] log_a [16];
    logic [31:0]   log_d [16];
    logic stall = 1'b0;
    logic stub_v = 1'b0;
    logic [31:0] stub_d = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cipher_dma_chan #(.AW(AW), .LW(LW)) dut (.*);

    // cipher stand-in: one-word register, result = input ^ KEY
    assign ci_ready = !stub_v && !stall;
    assign co_valid = stub_v;
    assign co_data  = stub_d ^ KEY;
    always @(posedge clk) begin
        if (!rst_n || error) stub_v <= 1'b0;
        else if (ci_valid && ci_ready) begin
            stub_v <= 1'b1;
            stub_d <= ci_data;
        end else if (co_valid && co_ready) stub_v <= 1'b0;
    end

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h0001_0003) ^ 32'h1357_9BDF;
    endfunction
    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // memory model, driven away from the active edge
    always @(negedge clk) begin
        gsel = gsel + 1;
        rd_gnt   = rd_req && (gsel % 3 != 1);
        rd_rdata = memf(rd_addr);
        rd_err   = rd_gnt && (rd_fires == rd_err_idx);
        wr_gnt   = wr_req && (gsel % 4 != 2);
        wr_err   = wr_gnt && (wr_n == wr_err_idx);
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rd_req && rd_gnt) rd_fires = rd_fires + 1;
        if (wr_req && wr_gnt) begin
            if (wr_n < 16) begin
                log_a[wr_n] = wr_addr;
                log_d[wr_n] = wr_data;
            end
            wr_n = wr_n + 1;
            last_wr_cyc = cyc;
        end
        if (done) begin done_n = done_n + 1; done_cyc = cyc; end
        if (error) err_n = err_n + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        rd_fires = 0; wr_n = 0; done_n = 0; err_n = 0;
    endtask

    task automatic kick(input logic [AW-1:0] rx, input logic [AW-1:0] tx, input int n,
                        input bit ri, input bit ti, input bit rs, input bit ts);
        @(negedge clk);
        rx_base = rx; tx_base = tx; len_words = LW'(n);
        rx_incr = ri; tx_incr = ti; rx_swap = rs; tx_swap = ts;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (done_n > 0 || err_n > 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic verify_data(input string req, input logic [AW-1:0] rx, input logic [AW-1:0] tx,
                               input int n, input bit ri, input bit ti, input bit rs, input bit ts);
        for (int i = 0; i < n && i < 16; i++) begin
            logic [31:0] a, d, ea;
            a  = {rx[31:2], 2'b00} + (ri ? 32'(4*i) : 32'd0);
            d  = memf(a);
            if (rs) d = rev(d);
            d  = d ^ KEY;
            if (ts) d = rev(d);
            ea = {tx[31:2], 2'b00} + (ti ? 32'(4*i) : 32'd0);
            check(log_a[i] == ea, {req, " write address"}, log_a[i], ea);
            check(log_d[i] == d,  {req, " write data"}, log_d[i], d);
        end
    endtask

    task automatic run_xfer(input string req, input logic [AW-1:0] rx, input logic [AW-1:0] tx,
                            input int n, input bit ri, input bit ti, input bit rs, input bit ts);
        clear_log();
        kick(rx, tx, n, ri, ti, rs, ts);
        wait_end();
        check(done_n == 1 && err_n == 0, {req, " done once, no error"}, 32'(done_n), 32'd1);
        check(rd_fires == n, "R1 read count", 32'(rd_fires), 32'(n));
        check(wr_n == n, "R1 write count", 32'(wr_n), 32'(n));
        check(done_cyc == last_wr_cyc + 1, "R4 done one cycle after last write",
              32'(done_cyc), 32'(last_wr_cyc + 1));
        verify_data(req, rx, tx, n, ri, ti, rs, ts);
        check(busy == 1'b0, {req, " idle after done"}, 32'(busy), 32'd0);
    endtask

    task automatic t_reset();
        check(!busy && !done && !error && !rd_req && !wr_req, "R10 reset state",
              {27'd0, busy, done, error, rd_req, wr_req}, 32'd0);
    endtask

    task automatic t_zero();
        clear_log();
        kick(32'h0000_4000, 32'h0000_5000, 0, 1, 1, 0, 0);
        repeat (5) @(negedge clk);
        check(done_n == 1, "R5 zero length done", 32'(done_n), 32'd1);
        check(rd_fires == 0 && wr_n == 0, "R5 zero length no requests", 32'(rd_fires + wr_n), 32'd0);
    endtask

    task automatic t_busy_start();
        clear_log();
        kick(32'h0000_0100, 32'h0000_0300, 5, 1, 1, 0, 0);
        repeat (3) @(negedge clk);
        rx_base = 32'h0000_0900; tx_base = 32'h0000_0A00; len_words = LW'(2);
        rx_swap = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end();
        check(done_n == 1 && wr_n == 5, "R7 start while busy ignored", 32'(wr_n), 32'd5);
        verify_data("R7", 32'h0000_0100, 32'h0000_0300, 5, 1, 1, 0, 0);
    endtask

    task automatic t_fifo();
        clear_log();
        stall = 1'b1;
        kick(32'h0000_2000, 32'h0000_3000, 8, 1, 1, 0, 0);
        repeat (40) @(negedge clk);
        check(rd_fires == 4, "R8 fifo depth stalls reads", 32'(rd_fires), 32'd4);
        stall = 1'b0;
        wait_end();
        check(done_n == 1 && wr_n == 8, "R8 drain after stall", 32'(wr_n), 32'd8);
        verify_data("R8", 32'h0000_2000, 32'h0000_3000, 8, 1, 1, 0, 0);
    endtask

    task automatic t_rd_err();
        clear_log();
        rd_err_idx = 2;
        kick(32'h0000_6000, 32'h0000_7000, 6, 1, 1, 0, 0);
        wait_end();
        repeat (20) @(negedge clk);
        rd_err_idx = -1;
        check(err_n == 1 && done_n == 0, "R6 read fault error without done", 32'(err_n), 32'd1);
        check(rd_fires == 3, "R6 reads stop after fault", 32'(rd_fires), 32'd3);
        check(!busy, "R6 idle after read fault", 32'(busy), 32'd0);
    endtask

    task automatic t_wr_err();
        clear_log();
        wr_err_idx = 1;
        kick(32'h0000_8000, 32'h0000_9000, 6, 1, 1, 0, 0);
        wait_end();
        repeat (20) @(negedge clk);
        wr_err_idx = -1;
        check(err_n == 1 && done_n == 0, "R6 write fault error without done", 32'(err_n), 32'd1);
        check(wr_n == 2, "R6 writes stop after fault", 32'(wr_n), 32'd2);
        check(!busy, "R6 idle after write fault", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        run_xfer("R2 incrementing", 32'h0000_1000, 32'h0000_1800, 6, 1, 1, 0, 0);
        run_xfer("R3 fixed with swap", 32'h0000_1100, 32'h0000_1900, 5, 0, 0, 1, 1);
        run_xfer("R2 R3 mixed unaligned", 32'h0000_1202, 32'h0000_1A03, 7, 1, 0, 1, 0);
        run_xfer("R9 restart new chunk", 32'h0000_1300, 32'h0000_1B00, 4, 0, 1, 0, 1);
        t_zero();
        t_busy_start();
        t_fifo();
        t_rd_err();
        t_wr_err();
        run_xfer("R9 restart after fault", 32'h0000_1400, 32'h0000_1C00, 3, 1, 1, 1, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule